// File: doc/BRIEF.md
# Byte-wide bus to APB bridge

This block lets an 8-bit microcontroller reach 32-bit APB subordinates through its external data memory port. The narrow side offers a 16-bit byte address, a write byte, and separate read and write strobes. It expects the whole access to finish in one clock. The bridge turns each narrow access into one or two APB transfers. It holds the narrow side by keeping its acknowledge low until the last APB transfer has completed.

On a read, the bridge fetches the aligned 32-bit word and hands back the byte that the low address bits select. On a write, a build-time parameter picks one of two modes:
- **Strobe mode** issues a single APB write with one lane strobe set.
- **Merge mode** is for subordinates that ignore strobes. It reads the aligned word, replaces one byte, and writes the whole word back.

A subordinate error on a completing transfer is passed back as a one-cycle error flag that comes with the acknowledge.

Top module: `byte_apb_bridge`

## Requirements
- R1: After a synchronous active-high reset, psel, penable, pwrite, pstrb, nb_ack and nb_err are all low.
- R2: Every APB transfer starts with one setup cycle (psel=1, penable=0), followed by access cycles (psel=1, penable=1). paddr is the narrow address with bits [1:0] cleared.
- R3: While psel=1, penable=1 and pready=0, the bridge keeps the access phase and holds paddr, pwrite and pwdata stable. The transfer completes on the first access cycle with pready=1.
- R4: A narrow read returns prdata[8n+7:8n] on nb_rdata, where n is address bits [1:0].
- R5: nb_ack is high for exactly one clock, in the cycle after the clock edge at which the final APB transfer completes. nb_rdata is valid in that same cycle. With w wait states per transfer, nb_ack is seen 3+w clocks after the request is taken for a read or a strobe-mode write, and 5+2w clocks after for a merge-mode write.
- R6: In strobe mode (USE_STROBE=1), a narrow write makes exactly one APB write and no APB read. pstrb has only bit n set (n = address bits [1:0]), and the write byte is copied into all four lanes of pwdata.
- R7: In merge mode (USE_STROBE=0), a narrow write makes an APB read of the aligned word, then an APB write with pstrb=4'b1111. The written word equals the read word with only lane n replaced by the write byte.
- R8: If pslverr=1 on a completing transfer, nb_err=1 in the same cycle as nb_ack. In merge mode, a read phase that ends in error ends the access without any APB write.
- R9: During every APB read, including the read phase of merge mode, pwrite=0 and pstrb=4'b0000.
- R10: A narrow request is taken only when the bridge is idle and nb_ack is low. Strobe changes during a transfer, and a request still held during the acknowledge cycle, start nothing. If both strobes are high when a request is taken, it is handled as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nb_addr | input | 16 | Narrow byte address |
| nb_wdata | input | 8 | Narrow write byte |
| nb_rd | input | 1 | Narrow read strobe |
| nb_wr | input | 1 | Narrow write strobe |
| nb_rdata | output | 8 | Narrow read byte |
| nb_ack | output | 1 | One-cycle completion acknowledge |
| nb_err | output | 1 | One-cycle error flag, given with nb_ack |
| paddr | output | 16 | APB word address |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable |
| pwrite | output | 1 | APB direction |
| pwdata | output | 32 | APB write data |
| pstrb | output | 4 | APB byte lane strobes |
| prdata | input | 32 | APB read data |
| pready | input | 1 | APB ready |
| pslverr | input | 1 | APB error |

## Verification
In merge mode, the completion of the read phase and the launch of the write phase fall on the same clock edge. At that edge the bridge must merge prdata into the new pwdata and, in the same step, decide between continuing and ending the access on error. The bench provokes this with random wait states and random subordinate errors. It judges the result from the APB read and write counts, the strobe and word seen by a bench subordinate model, and later read-back against a shadow memory. The acknowledge cycle also coincides with a request that is still held, and a directed case checks that this request starts no second transfer.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2
  } br_state_t;
endpackage

// File: rtl/bridge_lane_pick.sv
module bridge_lane_pick #(
  parameter int LANES = 4,
  localparam int LSB_W = $clog2(LANES)
) (
  input  logic [8*LANES-1:0] word,
  input  logic [LSB_W-1:0]   lane,
  output logic [7:0]         byte_o
);
  always_comb begin
    byte_o = 8'(word >> {lane, 3'b000});
  end
endmodule

// File: rtl/bridge_lane_merge.sv
module bridge_lane_merge #(
  parameter int LANES = 4,
  localparam int LSB_W = $clog2(LANES)
) (
  input  logic [8*LANES-1:0] word,
  input  logic [LSB_W-1:0]   lane,
  input  logic [7:0]         byte_i,
  output logic [8*LANES-1:0] merged
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign merged[8*i +: 8] = (lane == LSB_W'(i)) ? byte_i : word[8*i +: 8];
  end
endmodule

// File: rtl/byte_apb_bridge.sv
module byte_apb_bridge
  import bridge_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter bit USE_STROBE = 1'b1,
  localparam int LANES = DATA_W / 8,
  localparam int LSB_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] nb_addr,
  input  logic [7:0]        nb_wdata,
  input  logic              nb_rd,
  input  logic              nb_wr,
  output logic [7:0]        nb_rdata,
  output logic              nb_ack,
  output logic              nb_err,
  output logic [ADDR_W-1:0] paddr,
  output logic              psel,
  output logic              penable,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata,
  output logic [LANES-1:0]  pstrb,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pready,
  input  logic              pslverr
);
  br_state_t        state;
  logic             op_wr_q;
  logic             rmw_rd_q;
  logic [LSB_W-1:0] lane_q;
  logic [7:0]       byte_q;
  logic [7:0]       picked;
  logic [DATA_W-1:0] merged;
  logic             req_go;

  assign req_go = (state == ST_IDLE) && !nb_ack && (nb_rd || nb_wr);

  bridge_lane_pick #(.LANES(LANES)) i_pick (
    .word(prdata), .lane(lane_q), .byte_o(picked)
  );

  bridge_lane_merge #(.LANES(LANES)) i_merge (
    .word(prdata), .lane(lane_q), .byte_i(byte_q), .merged(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      op_wr_q  <= 1'b0;
      rmw_rd_q <= 1'b0;
      lane_q   <= '0;
      byte_q   <= '0;
      nb_rdata <= '0;
      nb_ack   <= 1'b0;
      nb_err   <= 1'b0;
      paddr    <= '0;
      psel     <= 1'b0;
      penable  <= 1'b0;
      pwrite   <= 1'b0;
      pwdata   <= '0;
      pstrb    <= '0;
    end else begin
      nb_ack <= 1'b0;
      nb_err <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_go) begin
            lane_q   <= nb_addr[LSB_W-1:0];
            byte_q   <= nb_wdata;
            op_wr_q  <= nb_wr;
            rmw_rd_q <= nb_wr && !USE_STROBE;
            paddr    <= {nb_addr[ADDR_W-1:LSB_W], {LSB_W{1'b0}}};
            psel     <= 1'b1;
            penable  <= 1'b0;
            if (nb_wr && USE_STROBE) begin
              pwrite <= 1'b1;
              pwdata <= {LANES{nb_wdata}};
              pstrb  <= LANES'(1) << nb_addr[LSB_W-1:0];
            end else begin
              pwrite <= 1'b0;
              pstrb  <= '0;
            end
            state <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          penable <= 1'b1;
          state   <= ST_ACCESS;
        end
        ST_ACCESS: begin
          if (pready) begin
            if (rmw_rd_q && !pslverr) begin
              rmw_rd_q <= 1'b0;
              pwrite   <= 1'b1;
              pwdata   <= merged;
              pstrb    <= '1;
              penable  <= 1'b0;
              state    <= ST_SETUP;
            end else begin
              psel     <= 1'b0;
              penable  <= 1'b0;
              pwrite   <= 1'b0;
              pstrb    <= '0;
              rmw_rd_q <= 1'b0;
              nb_ack   <= 1'b1;
              nb_err   <= pslverr;
              if (!op_wr_q) nb_rdata <= picked;
              state    <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Protocol checks
  assert_paddr_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    psel |-> (paddr[LSB_W-1:0] == '0));
  assert_setup_then_access_R2: assert property (@(posedge clk) disable iff (rst)
    (psel && !penable) |=> (psel && penable));
  assert_wait_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && !pready) |=>
      (psel && penable && $stable(paddr) && $stable(pwrite) && $stable(pwdata)));
  assert_ack_single_R5: assert property (@(posedge clk) disable iff (rst)
    nb_ack |=> !nb_ack);
  assert_err_only_with_ack_R8: assert property (@(posedge clk) disable iff (rst)
    nb_err |-> nb_ack);
  assert_read_no_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    (psel && !pwrite) |-> (pstrb == '0));
  assert_ack_idle_R10: assert property (@(posedge clk) disable iff (rst)
    nb_ack |-> !psel);

  if (USE_STROBE) begin : g_strobe_chk
    assert_one_lane_R6: assert property (@(posedge clk) disable iff (rst)
      (psel && pwrite) |-> ($countones(pstrb) == 1));
  end else begin : g_merge_chk
    assert_full_word_R7: assert property (@(posedge clk) disable iff (rst)
      (psel && pwrite) |-> (pstrb == '1));
  end
endmodule

// File: tb/test_byte_apb_bridge.sv
module apb_sub_model #(
  parameter bit STROBE_OK = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [15:0] paddr,
  input  logic [31:0] pwdata,
  input  logic [3:0]  pstrb,
  input  logic [1:0]  wait_cfg,
  input  logic        err_cfg,
  output logic [31:0] prdata,
  output logic        pready,
  output logic        pslverr,
  output int          n_rd,
  output int          n_wr,
  output logic [3:0]  last_strb,
  output logic [31:0] last_wdata,
  output logic        bad_rd
);
  logic [31:0] mem [16];
  logic [1:0]  cnt;

  assign pready  = psel && penable && (cnt == wait_cfg);
  assign pslverr = pready && err_cfg;
  assign prdata  = mem[paddr[5:2]];

  initial begin
    for (int k = 0; k < 16; k++) mem[k] = 32'hA5C3_0F17 ^ (k * 32'h0105_0B13);
  end

  always @(posedge clk) begin
    if (rst) begin
      cnt <= 0; n_rd <= 0; n_wr <= 0; last_strb <= 0; last_wdata <= 0; bad_rd <= 0;
    end else begin
      if (psel && penable && !pready) cnt <= cnt + 2'd1;
      else cnt <= 0;
      if (psel && !pwrite && pstrb != 4'b0000) bad_rd <= 1'b1;
      if (pready) begin
        if (pwrite) begin
          n_wr <= n_wr + 1;
          last_strb <= pstrb;
          last_wdata <= pwdata;
          if (!err_cfg) begin
            for (int b = 0; b < 4; b++)
              if (pstrb[b] || !STROBE_OK) mem[paddr[5:2]][8*b +: 8] <= pwdata[8*b +: 8];
          end
        end else begin
          n_rd <= n_rd + 1;
        end
      end
    end
  end
endmodule

module test_byte_apb_bridge;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [15:0] nb_addr [2];
  logic [7:0]  nb_wdata [2];
  logic        nb_rd [2];
  logic        nb_wr [2];
  logic [7:0]  nb_rdata [2];
  logic        nb_ack [2];
  logic        nb_err [2];
  logic [15:0] paddr [2];
  logic        psel [2];
  logic        penable [2];
  logic        pwrite [2];
  logic [31:0] pwdata [2];
  logic [3:0]  pstrb [2];
  logic [31:0] prdata [2];
  logic        pready [2];
  logic        pslverr [2];
  logic [1:0]  wait_cfg [2];
  logic        err_cfg [2];
  int          n_rd [2];
  int          n_wr [2];
  logic [3:0]  last_strb [2];
  logic [31:0] last_wdata [2];
  logic        bad_rd [2];

  // mode 0: strobe mode, mode 1: merge mode
  for (genvar m = 0; m < 2; m++) begin : g_mode
    byte_apb_bridge #(.USE_STROBE(m == 0)) i_byte_apb_bridge (
      .clk(clk), .rst(rst),
      .nb_addr(nb_addr[m]), .nb_wdata(nb_wdata[m]), .nb_rd(nb_rd[m]), .nb_wr(nb_wr[m]),
      .nb_rdata(nb_rdata[m]), .nb_ack(nb_ack[m]), .nb_err(nb_err[m]),
      .paddr(paddr[m]), .psel(psel[m]), .penable(penable[m]), .pwrite(pwrite[m]),
      .pwdata(pwdata[m]), .pstrb(pstrb[m]), .prdata(prdata[m]),
      .pready(pready[m]), .pslverr(pslverr[m])
    );
    apb_sub_model #(.STROBE_OK(m == 0)) i_sub (
      .clk(clk), .rst(rst), .psel(psel[m]), .penable(penable[m]), .pwrite(pwrite[m]),
      .paddr(paddr[m]), .pwdata(pwdata[m]), .pstrb(pstrb[m]),
      .wait_cfg(wait_cfg[m]), .err_cfg(err_cfg[m]),
      .prdata(prdata[m]), .pready(pready[m]), .pslverr(pslverr[m]),
      .n_rd(n_rd[m]), .n_wr(n_wr[m]), .last_strb(last_strb[m]),
      .last_wdata(last_wdata[m]), .bad_rd(bad_rd[m])
    );
  end

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  logic [7:0] sh [2][64];

  function automatic logic [31:0] init_word(int k);
    return 32'hA5C3_0F17 ^ (k * 32'h0105_0B13);
  endfunction

  function automatic logic [31:0] shadow_word(int m, int a);
    int base = a & 60;
    return {sh[m][base+3], sh[m][base+2], sh[m][base+1], sh[m][base]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  // One narrow access; is_wr/both/hold select variants
  task automatic xfer(int m, bit is_wr, bit both, bit hold, int a, logic [7:0] d,
                      logic [1:0] w, bit e, bit chk_lat);
    int cnt = 0;
    int rd0 = n_rd[m];
    int wr0 = n_wr[m];
    int exp_lat;
    bit eff_wr = is_wr || both;
    logic [31:0] exp_word;
    @(negedge clk);
    wait_cfg[m] = w; err_cfg[m] = e;
    nb_addr[m] = 16'(a); nb_wdata[m] = d;
    nb_rd[m] = !is_wr || both; nb_wr[m] = eff_wr;
    do begin
      @(negedge clk);
      cnt++;
      if (cnt == 2 && !hold) begin
        nb_wr[m] = !eff_wr;  // strobe change while busy must be ignored
        nb_rd[m] = eff_wr;
        nb_addr[m] = 16'(a ^ 5);
      end
    end while (!nb_ack[m] && cnt < 100);
    exp_lat = (m == 1 && eff_wr && !e) ? 5 + 2*w : 3 + w;
    if (chk_lat) check("R5 latency", cnt, exp_lat);
    check("R8 err flag", nb_err[m], e);
    if (!eff_wr && !e) check("R4 read byte", nb_rdata[m], sh[m][a]);
    if (eff_wr && !e) sh[m][a] = d;
    if (hold) @(negedge clk);
    nb_rd[m] = 0; nb_wr[m] = 0;
    @(negedge clk);
    check("R5 ack single", nb_ack[m], 0);
    repeat (2) @(negedge clk);
    check("R10 no extra start", psel[m], 0);
    if (!eff_wr) begin
      check("R10 reads", n_rd[m] - rd0, 1);
      check("R10 writes", n_wr[m] - wr0, 0);
    end else if (m == 0) begin
      check("R6 reads", n_rd[m] - rd0, 0);
      check("R6 writes", n_wr[m] - wr0, 1);
      check("R6 strobe", last_strb[m], 4'b0001 << (a & 3));
      check("R6 replicate", last_wdata[m], {4{d}});
    end else begin
      check("R7 reads", n_rd[m] - rd0, 1);
      check("R8 writes", n_wr[m] - wr0, e ? 0 : 1);
      if (!e) begin
        exp_word = shadow_word(m, a);
        check("R7 strobe", last_strb[m], 4'hF);
        check("R7 merged", last_wdata[m], exp_word);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int m = 0; m < 2; m++) begin
      nb_addr[m] = 0; nb_wdata[m] = 0; nb_rd[m] = 0; nb_wr[m] = 0;
      wait_cfg[m] = 0; err_cfg[m] = 0;
      for (int k = 0; k < 64; k++) sh[m][k] = 8'(init_word(k / 4) >> (8 * (k % 4)));
    end
    repeat (3) @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      check("R1 psel", psel[m], 0);
      check("R1 penable", penable[m], 0);
      check("R1 ack", nb_ack[m], 0);
      check("R1 err", nb_err[m], 0);
      check("R1 pstrb", pstrb[m], 0);
    end
    @(negedge clk); rst = 0;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      // directed corners
      xfer(m, 0, 0, 0, 7, 8'h00, 0, 0, 1);      // read lane 3, no wait
      xfer(m, 1, 0, 0, 4, 8'h3C, 2, 0, 1);      // write lane 0, waits
      xfer(m, 0, 0, 0, 4, 8'h00, 1, 0, 1);      // read back R7/R6
      xfer(m, 1, 0, 0, 9, 8'hE1, 1, 1, 1);      // write with error R8
      xfer(m, 0, 0, 0, 9, 8'h00, 0, 0, 1);      // unchanged after error
      xfer(m, 0, 0, 1, 14, 8'h00, 2, 0, 1);     // held through ack R10
      xfer(m, 0, 1, 0, 30, 8'h77, 0, 0, 1);     // both strobes -> write R10
      xfer(m, 0, 0, 0, 30, 8'h00, 0, 0, 1);
      for (int i = 0; i < 150; i++) begin
        int a = $urandom_range(0, 63);
        bit wr = $urandom_range(0, 1) == 1;
        logic [7:0] d = 8'($urandom);
        logic [1:0] w = 2'($urandom_range(0, 2));
        bit e = $urandom_range(0, 7) == 0;
        xfer(m, wr, 0, 0, a, d, w, e, 1);
      end
      for (int a = 0; a < 64; a += 3) xfer(m, 0, 0, 0, a, 8'h00, 0, 0, 0);
      check("R9 read strobes", bad_rd[m], 0);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule